// File: doc/BRIEF.md
# Serial Bit Error Rate Tester

This block drives a test bitstream out of one serial lane and checks a bitstream that comes back on another. Both lanes advance one bit per clock cycle in which their valid enable is high. The generator sends a pseudorandom sequence from one of five polynomials, or a user word of programmable length repeated without end. The generator can flip a single bit on command. It can also flip bits automatically, once every ten, hundred and so on bits up to ten million.

The checker aligns itself to the incoming stream without outside help. Once locked, it counts received bits and mismatching bits. It drops lock when errors cluster. A load strobe copies both running counts into holding outputs and restarts the counts from zero. A sticky flag records that the error counter wrapped. Both lanes use the same pattern selection, so the generator output can be looped back to the checker input for a self test.

Top module: `bert_core`

## Requirements
- R1: After reset, tx_data, in_sync, err_ovf, bit_hold and err_hold are all 0.
- R2: pat_sel codes 0 to 4 select the pseudorandom sequences with recurrences b[n] = b[n-7]^b[n-6], b[n-11]^b[n-9], b[n-15]^b[n-14], b[n-20]^b[n-17] and b[n-23]^b[n-18]. Every change of pat_sel restarts the generator from an all-ones history.
- R3: pat_sel codes 5 to 7 select the repeated word. Its length is 17 + len_code bits, and it is sent bit 0 of rep_word first. A change of pat_sel restarts it at bit 0. The checker locks to and counts the same repeated word.
- R4: The generator advances one bit per cycle with tx_en high. While tx_en is low, tx_data holds its value and the sequence position is kept.
- R5: tx_inv inverts every transmitted bit. rx_inv inverts every received bit before it is compared.
- R6: A one-cycle err_inject pulse flips exactly one bit: the next bit transmitted.
- R7: rate_sel = k (1 to 7) flips one transmitted bit in every 10^k. Counting from the last change of rate_sel, the flipped bits are the bits with index n where n mod 10^k = 10^k - 1. rate_sel = 0 flips none.
- R8: in_sync rises only after 32 consecutive valid received bits that match the pattern predicted from earlier bits.
- R9: While locked, six errors within 64 valid bits, counted from the first error of a burst, clear in_sync. Five such errors do not.
- R10: While locked, each valid bit adds one to the bit counter and each mismatching valid bit adds one to the ERR_W-bit error counter (24 by default). Nothing is counted while rx_en is low or while out of lock.
- R11: A cnt_load pulse copies both counters to bit_hold and err_hold and clears the counters. The holding outputs change at no other time.
- R12: err_ovf sets when the error counter wraps to zero. It stays set, even across cnt_load, until an ovf_clr pulse clears it.
- R13: A resync pulse, or a change of pat_sel, clears in_sync at once and restarts acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_sel | input | 3 | Pattern selection shared by both lanes |
| len_code | input | 4 | Repeated word length minus 17 |
| rep_word | input | 32 | Repeated word, bit 0 sent first |
| rate_sel | input | 3 | Automatic error rate, decade exponent |
| tx_inv | input | 1 | Invert transmitted bits |
| rx_inv | input | 1 | Invert received bits |
| err_inject | input | 1 | Flip the next transmitted bit |
| tx_en | input | 1 | Transmit bit enable |
| tx_data | output | 1 | Transmitted bit |
| rx_en | input | 1 | Received bit valid |
| rx_data | input | 1 | Received bit |
| resync | input | 1 | Force reacquisition |
| cnt_load | input | 1 | Copy counts to holding outputs and clear |
| ovf_clr | input | 1 | Clear the overflow flag (read strobe) |
| in_sync | output | 1 | Checker locked |
| err_ovf | output | 1 | Error counter wrapped |
| bit_hold | output | BIT_W | Held bit count |
| err_hold | output | ERR_W | Held error count |

## Verification
The embedded properties watch, on every cycle, the invariants that hold whatever the data: tx_data holds with tx_en low, and counters freeze when idle or unlocked. They also check that the holding outputs move only on a load, that the overflow flag is sticky, that resync drops lock in the next cycle, and that the generator history never becomes all zero. The actual bit sequences can only be confirmed by the bench's scenarios. These cover the polynomial recurrences, the repeated word order, the exact positions of rate-driven flips, the 31-bit no-lock window, the five-versus-six error burst boundary, and the wrap of a shortened error counter.

// File: rtl/bert_pkg.sv
package bert_pkg;
    localparam int SR_W  = 32;
    localparam int IDX_W = 5;

    function automatic logic is_rep(input logic [2:0] sel);
        return sel >= 3'd5;
    endfunction

    // index of the older feedback tap in the history register
    function automatic logic [IDX_W-1:0] tap_hi(input logic [2:0] sel);
        case (sel)
            3'd1:    return 5'd10;
            3'd2:    return 5'd14;
            3'd3:    return 5'd19;
            3'd4:    return 5'd22;
            default: return 5'd6;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] tap_lo(input logic [2:0] sel);
        case (sel)
            3'd1:    return 5'd8;
            3'd2:    return 5'd13;
            3'd3:    return 5'd16;
            3'd4:    return 5'd17;
            default: return 5'd5;
        endcase
    endfunction

    // last index of the repeated word: length 17 + code
    function automatic logic [IDX_W-1:0] rep_last(input logic [3:0] code);
        return {1'b0, code} + 5'd16;
    endfunction
endpackage

// File: rtl/bert_gen.sv
module bert_gen
    import bert_pkg::*;
#(
    parameter int DIGITS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      pat_sel,
    input  logic [3:0]      len_code,
    input  logic [SR_W-1:0] rep_word,
    input  logic [2:0]      rate_sel,
    input  logic            tx_inv,
    input  logic            err_inject,
    input  logic            tx_en,
    output logic            tx_data
);
    typedef struct packed {
        logic [SR_W-1:0]         sreg;
        logic [IDX_W-1:0]        idx;
        logic [2:0]              pat;
        logic [2:0]              rate;
        logic                    pend;
        logic                    tx;
        logic [DIGITS-1:0][3:0]  digits;
    } gen_t;

    gen_t q, d;

    logic                   rate_chg;
    logic [DIGITS-1:0][3:0] base_dg;
    logic [DIGITS-1:0]      nine_v;
    logic [DIGITS-1:0]      need_v;

    assign rate_chg = (rate_sel != q.rate);
    assign base_dg  = rate_chg ? '0 : q.digits;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign nine_v[g] = (base_dg[g] == 4'd9);
        assign need_v[g] = (g < int'(rate_sel));
    end

    logic fb, nb, auto_flip, carry;
    logic [DIGITS-1:0][3:0] dg;

    always_comb begin
        d         = q;
        dg        = base_dg;
        d.rate    = rate_sel;
        fb        = q.sreg[tap_hi(q.pat)] ^ q.sreg[tap_lo(q.pat)];
        nb        = is_rep(q.pat) ? rep_word[q.idx] : fb;
        auto_flip = (rate_sel != 3'd0) && (&(nine_v | ~need_v));
        carry     = 1'b1;
        if (pat_sel != q.pat) begin
            d.pat  = pat_sel;
            d.sreg = '1;
            d.idx  = '0;
        end else if (tx_en) begin
            d.sreg = {q.sreg[SR_W-2:0], fb};
            d.idx  = (q.idx >= rep_last(len_code)) ? '0 : q.idx + 5'd1;
            d.tx   = nb ^ tx_inv ^ (auto_flip | q.pend);
            d.pend = 1'b0;
            for (int i = 0; i < DIGITS; i++) begin
                if (carry) begin
                    if (dg[i] == 4'd9) begin
                        dg[i] = 4'd0;
                    end else begin
                        dg[i] = dg[i] + 4'd1;
                        carry = 1'b0;
                    end
                end
            end
        end
        if (err_inject) d.pend = 1'b1;
        d.digits = dg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sreg <= '1;
        end else begin
            q <= d;
        end
    end

    assign tx_data = q.tx;

    // R4: output frozen while no bit is requested
    a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> $stable(tx_data));
    // R2: the history never collapses to the all-zero lock-up state
    a_r2_history_live: assert property (@(posedge clk) disable iff (!rst_n)
        q.sreg != '0);
    // R6: a pending single flip is spent by the next transmitted bit
    a_r6_pend_spent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && tx_en && !err_inject && pat_sel == q.pat) |=> !q.pend);
endmodule

// File: rtl/bert_chk.sv
module bert_chk
    import bert_pkg::*;
#(
    parameter int BIT_W = 32,
    parameter int ERR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       pat_sel,
    input  logic [3:0]       len_code,
    input  logic             rx_inv,
    input  logic             rx_en,
    input  logic             rx_data,
    input  logic             resync,
    input  logic             cnt_load,
    input  logic             ovf_clr,
    output logic             in_sync,
    output logic             err_ovf,
    output logic [BIT_W-1:0] bit_hold,
    output logic [ERR_W-1:0] err_hold
);
    localparam int RUN_LOCK = 31;
    localparam int WIN_LEN  = 64;
    localparam int WIN_ERRS = 6;

    typedef struct packed {
        logic [SR_W-1:0]  sreg;
        logic             sync;
        logic [5:0]       run;
        logic             wact;
        logic [6:0]       wcnt;
        logic [2:0]       werr;
        logic [BIT_W-1:0] bcnt;
        logic [ERR_W-1:0] ecnt;
        logic [BIT_W-1:0] bhold;
        logic [ERR_W-1:0] ehold;
        logic             ovf;
        logic [2:0]       pat;
    } chk_t;

    chk_t q, d;

    logic             rb, expb, mis, wa;
    logic [6:0]       wc;
    logic [2:0]       we;
    logic [BIT_W-1:0] bc;
    logic [ERR_W-1:0] ec;

    always_comb begin
        d    = q;
        rb   = rx_data ^ rx_inv;
        expb = is_rep(pat_sel) ? q.sreg[rep_last(len_code)]
                               : q.sreg[tap_hi(pat_sel)] ^ q.sreg[tap_lo(pat_sel)];
        mis  = rb ^ expb;
        bc   = q.bcnt;
        ec   = q.ecnt;
        wa   = q.wact | mis;
        wc   = q.wact ? q.wcnt + 7'd1 : 7'd1;
        we   = q.wact ? q.werr + {2'b00, mis} : {2'b00, mis};
        if (cnt_load) begin
            d.bhold = q.bcnt;
            d.ehold = q.ecnt;
            bc      = '0;
            ec      = '0;
        end
        if (ovf_clr) d.ovf = 1'b0;
        if (rx_en) begin
            if (!q.sync) begin
                d.sreg = {q.sreg[SR_W-2:0], rb};
                if (mis) begin
                    d.run = '0;
                end else if (q.run == 6'(RUN_LOCK)) begin
                    d.sync = 1'b1;
                    d.run  = '0;
                end else begin
                    d.run = q.run + 6'd1;
                end
            end else begin
                d.sreg = {q.sreg[SR_W-2:0], expb};
                bc     = bc + BIT_W'(1);
                if (mis) begin
                    ec = ec + ERR_W'(1);
                    if (ec == '0) d.ovf = 1'b1;
                end
                if (wa && we == 3'(WIN_ERRS)) begin
                    d.sync = 1'b0;
                    d.run  = '0;
                    d.wact = 1'b0;
                    d.wcnt = '0;
                    d.werr = '0;
                end else if (wa && wc == 7'(WIN_LEN)) begin
                    d.wact = 1'b0;
                    d.wcnt = '0;
                    d.werr = '0;
                end else if (wa) begin
                    d.wact = 1'b1;
                    d.wcnt = wc;
                    d.werr = we;
                end
            end
        end
        if (resync || pat_sel != q.pat) begin
            d.sync = 1'b0;
            d.run  = '0;
            d.wact = 1'b0;
            d.wcnt = '0;
            d.werr = '0;
            d.pat  = pat_sel;
        end
        d.bcnt = bc;
        d.ecnt = ec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_sync  = q.sync;
    assign err_ovf  = q.ovf;
    assign bit_hold = q.bhold;
    assign err_hold = q.ehold;

    // R8: lock is only ever gained on a valid bit
    a_r8_lock_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sync) |-> $past(rx_en));
    // R10: idle lane leaves the bit counter alone
    a_r10_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !cnt_load) |=> $stable(q.bcnt));
    // R10: no errors are counted out of lock
    a_r10_unlocked_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.sync && !cnt_load) |=> $stable(q.ecnt));
    // R11: holding outputs move only on a load
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_load |=> ($stable(bit_hold) && $stable(err_hold)));
    // R11: a load on an idle lane leaves both counters at zero
    a_r11_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_load && !rx_en) |=> (q.bcnt == '0 && q.ecnt == '0));
    // R12: overflow flag is sticky until cleared
    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf && !ovf_clr) |=> err_ovf);
    // R13: resync drops lock in the next cycle
    a_r13_resync_drop: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !in_sync);
endmodule

// File: rtl/bert_core.sv
module bert_core
    import bert_pkg::*;
#(
    parameter int BIT_W  = 32,
    parameter int ERR_W  = 24,
    parameter int DIGITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       pat_sel,
    input  logic [3:0]       len_code,
    input  logic [31:0]      rep_word,
    input  logic [2:0]       rate_sel,
    input  logic             tx_inv,
    input  logic             rx_inv,
    input  logic             err_inject,
    input  logic             tx_en,
    output logic             tx_data,
    input  logic             rx_en,
    input  logic             rx_data,
    input  logic             resync,
    input  logic             cnt_load,
    input  logic             ovf_clr,
    output logic             in_sync,
    output logic             err_ovf,
    output logic [BIT_W-1:0] bit_hold,
    output logic [ERR_W-1:0] err_hold
);
    bert_gen #(.DIGITS(DIGITS)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_sel    (pat_sel),
        .len_code   (len_code),
        .rep_word   (rep_word),
        .rate_sel   (rate_sel),
        .tx_inv     (tx_inv),
        .err_inject (err_inject),
        .tx_en      (tx_en),
        .tx_data    (tx_data)
    );

    bert_chk #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .pat_sel  (pat_sel),
        .len_code (len_code),
        .rx_inv   (rx_inv),
        .rx_en    (rx_en),
        .rx_data  (rx_data),
        .resync   (resync),
        .cnt_load (cnt_load),
        .ovf_clr  (ovf_clr),
        .in_sync  (in_sync),
        .err_ovf  (err_ovf),
        .bit_hold (bit_hold),
        .err_hold (err_hold)
    );
endmodule

// File: tb/bert_core_test.sv
module bert_core_test;
    localparam int EW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [2:0]  pat_sel = 3'd0;
    logic [3:0]  len_code = 4'd0;
    logic [31:0] rep_word = 32'h0;
    logic [2:0]  rate_sel = 3'd0;
    logic        tx_inv = 1'b0, rx_inv = 1'b0, err_inject = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0, rx_data = 1'b0;
    logic        resync = 1'b0, cnt_load = 1'b0, ovf_clr = 1'b0;
    logic        tx_data, in_sync, err_ovf;
    logic [31:0] bit_hold;
    logic [EW-1:0] err_hold;

    bert_core #(.ERR_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .len_code(len_code),
        .rep_word(rep_word), .rate_sel(rate_sel), .tx_inv(tx_inv), .rx_inv(rx_inv),
        .err_inject(err_inject), .tx_en(tx_en), .tx_data(tx_data), .rx_en(rx_en),
        .rx_data(rx_data), .resync(resync), .cnt_load(cnt_load), .ovf_clr(ovf_clr),
        .in_sync(in_sync), .err_ovf(err_ovf), .bit_hold(bit_hold), .err_hold(err_hold)
    );

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    logic cap [0:4095];

    logic [31:0] m_sr;
    int          m_idx;
    logic [2:0]  m_sel;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int hi_tap(input logic [2:0] s);
        case (s) 3'd1: return 10; 3'd2: return 14; 3'd3: return 19; 3'd4: return 22; default: return 6; endcase
    endfunction
    function automatic int lo_tap(input logic [2:0] s);
        case (s) 3'd1: return 8; 3'd2: return 13; 3'd3: return 16; 3'd4: return 17; default: return 5; endcase
    endfunction

    task automatic model_start(input logic [2:0] s);
        m_sel = s; m_sr = '1; m_idx = 0;
    endtask

    task automatic next_model(output logic b);
        if (m_sel >= 3'd5) begin
            b = rep_word[m_idx];
            m_idx = (m_idx == 16 + int'(len_code)) ? 0 : m_idx + 1;
        end else begin
            b = m_sr[hi_tap(m_sel)] ^ m_sr[lo_tap(m_sel)];
            m_sr = {m_sr[30:0], b};
        end
    endtask

    task automatic rx_bit(input bit flip, input bit inv);
        logic b;
        next_model(b);
        rx_data = b ^ flip ^ inv;
        rx_en = 1'b1;
        @(negedge clk);
        rx_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load();
        cnt_load = 1'b1; @(negedge clk); cnt_load = 1'b0;
    endtask

    task automatic hunt(input bit inv);
        for (int i = 0; i < 200 && !in_sync; i++) rx_bit(1'b0, inv);
    endtask

    task automatic tx_cap(input int n);
        tx_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap[i] = tx_data;
        end
        tx_en = 1'b0;
    endtask

    task automatic gen_restart(input logic [2:0] s);
        pat_sel = (s == 3'd0) ? 3'd1 : 3'd0;
        idle(2);
        pat_sel = s;
        idle(2);
    endtask

    function automatic int rep_len();
        return 17 + int'(len_code);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int bad, flips, n, r;
        void'($urandom(32'd7351));
        idle(3);
        // R1: reset state
        check(tx_data == 1'b0, "R1 tx_data", tx_data, 0);
        check(in_sync == 1'b0, "R1 in_sync", in_sync, 0);
        check(err_ovf == 1'b0, "R1 err_ovf", err_ovf, 0);
        check(bit_hold == 0 && err_hold == 0, "R1 holds", bit_hold, 0);
        rst_n = 1'b1;
        idle(2);

        // R2: each polynomial obeys its recurrence
        for (int s = 0; s < 5; s++) begin
            gen_restart(3'(s));
            tx_cap(300);
            bad = 0; flips = 0;
            for (int k = 24; k < 300; k++)
                if (cap[k] !== (cap[k-1-hi_tap(3'(s))] ^ cap[k-1-lo_tap(3'(s))])) bad++;
            for (int k = 0; k < 300; k++) flips += int'(cap[k]);
            check(bad == 0, $sformatf("R2 recurrence sel%0d", s), bad, 0);
            check(flips > 0 && flips < 300, $sformatf("R2 mixed bits sel%0d", s), flips, 150);
            if (s == 0) begin
                bad = 0;
                for (int k = 127; k < 300; k++) if (cap[k] !== cap[k-127]) bad++;
                check(bad == 0, "R2 period 127", bad, 0);
            end
        end

        // R3: repeated word, random length and content
        rep_word = $urandom();
        len_code = 4'($urandom_range(0, 15));
        gen_restart(3'd5);
        n = 3 * rep_len();
        tx_cap(n);
        bad = 0;
        for (int k = 0; k < n; k++) if (cap[k] !== rep_word[k % rep_len()]) bad++;
        check(bad == 0, "R3 repeated word order", bad, 0);
        // R4: pause keeps output and position
        r = int'(cap[n-1]);
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (tx_data !== 1'(r)) bad++;
        end
        check(bad == 0, "R4 tx_data holds", bad, 0);
        tx_cap(1);
        check(cap[0] === rep_word[0], "R4 position kept", cap[0], rep_word[0]);

        // R5: transmit inversion
        tx_inv = 1'b1;
        gen_restart(3'd7);
        tx_cap(40);
        bad = 0;
        for (int k = 0; k < 40; k++) if (cap[k] !== ~rep_word[k % rep_len()]) bad++;
        check(bad == 0, "R5 tx inversion", bad, 0);
        tx_inv = 1'b0;

        // R6: single injected error
        gen_restart(3'd5);
        err_inject = 1'b1; @(negedge clk); err_inject = 1'b0;
        tx_cap(40);
        flips = 0;
        for (int k = 0; k < 40; k++) if (cap[k] !== rep_word[k % rep_len()]) flips++;
        check(flips == 1, "R6 one flip", flips, 1);
        check(cap[0] !== rep_word[0], "R6 flip on next bit", cap[0], ~rep_word[0]);

        // R7: rate 1e-1, 1e-2, none
        rate_sel = 3'd1;
        gen_restart(3'd5);
        tx_cap(200);
        bad = 0; flips = 0;
        for (int k = 0; k < 200; k++) begin
            if ((cap[k] !== rep_word[k % rep_len()]) != (k % 10 == 9)) bad++;
            if (cap[k] !== rep_word[k % rep_len()]) flips++;
        end
        check(bad == 0, "R7 rate1 positions", bad, 0);
        check(flips == 20, "R7 rate1 count", flips, 20);
        rate_sel = 3'd2;
        gen_restart(3'd5);
        tx_cap(300);
        bad = 0;
        for (int k = 0; k < 300; k++)
            if ((cap[k] !== rep_word[k % rep_len()]) != (k % 100 == 99)) bad++;
        check(bad == 0, "R7 rate2 positions", bad, 0);
        rate_sel = 3'd0;
        gen_restart(3'd5);
        tx_cap(120);
        flips = 0;
        for (int k = 0; k < 120; k++) if (cap[k] !== rep_word[k % rep_len()]) flips++;
        check(flips == 0, "R7 rate0 none", flips, 0);

        // R8: acquisition on PRBS7
        pat_sel = 3'd0; idle(2);
        resync = 1'b1; @(negedge clk); resync = 1'b0;
        model_start(3'd0);
        for (int k = 0; k < 31; k++) rx_bit(1'b0, 1'b0);
        check(in_sync == 1'b0, "R8 no lock before 32", in_sync, 0);
        hunt(1'b0);
        check(in_sync == 1'b1, "R8 lock", in_sync, 1);

        // R10, R11: clean and errored runs
        do_load();
        n = $urandom_range(100, 300);
        for (int k = 0; k < n; k++) rx_bit(1'b0, 1'b0);
        do_load();
        check(bit_hold == 32'(n), "R11 bit_hold", bit_hold, n);
        check(err_hold == 0, "R10 no errors", err_hold, 0);
        r = $urandom_range(0, 100);
        for (int k = 0; k < 200; k++) rx_bit(k == r || k == r + 30 || k == r + 90, 1'b0);
        check(in_sync == 1'b1, "R9 three errors keep lock", in_sync, 1);
        do_load();
        check(err_hold == 3, "R10 err count", err_hold, 3);
        check(bit_hold == 200, "R10 bit count", bit_hold, 200);
        for (int k = 0; k < 20; k++) rx_bit(1'b0, 1'b0);
        check(bit_hold == 200, "R11 hold unchanged", bit_hold, 200);
        idle(10);
        do_load();
        check(bit_hold == 20, "R10 idle not counted", bit_hold, 20);

        // R9: burst boundary
        for (int k = 0; k < 5; k++) rx_bit(1'b1, 1'b0);
        check(in_sync == 1'b1, "R9 five errors keep lock", in_sync, 1);
        for (int k = 0; k < 70; k++) rx_bit(1'b0, 1'b0);
        for (int k = 0; k < 6; k++) rx_bit(1'b1, 1'b0);
        check(in_sync == 1'b0, "R9 six errors drop lock", in_sync, 0);

        // R13: resync
        hunt(1'b0);
        check(in_sync == 1'b1, "R13 relock", in_sync, 1);
        resync = 1'b1; @(negedge clk); resync = 1'b0;
        check(in_sync == 1'b0, "R13 resync drops", in_sync, 0);
        for (int k = 0; k < 31; k++) rx_bit(1'b0, 1'b0);
        check(in_sync == 1'b0, "R13 restart window", in_sync, 0);

        // R5: receive inversion on PRBS15
        rx_inv = 1'b1;
        pat_sel = 3'd2; idle(2);
        model_start(3'd2);
        hunt(1'b1);
        check(in_sync == 1'b1, "R5 rx inverted lock", in_sync, 1);
        do_load();
        for (int k = 0; k < 150; k++) rx_bit(1'b0, 1'b1);
        do_load();
        check(err_hold == 0 && bit_hold == 150, "R5 rx inverted clean", err_hold, 0);
        rx_inv = 1'b0;

        // R3: checker on repeated word
        rep_word = $urandom();
        len_code = 4'($urandom_range(0, 15));
        pat_sel = 3'd6; idle(2);
        model_start(3'd6);
        hunt(1'b0);
        check(in_sync == 1'b1, "R3 rep lock", in_sync, 1);
        do_load();
        for (int k = 0; k < 100; k++) rx_bit(k == 10 || k == 50, 1'b0);
        do_load();
        check(err_hold == 2, "R3 rep errors", err_hold, 2);

        // R12: error counter wrap (ERR_W = 8 here)
        pat_sel = 3'd0; idle(2);
        model_start(3'd0);
        hunt(1'b0);
        do_load();
        for (int e = 0; e < 256; e++) begin
            for (int k = 0; k < 15; k++) rx_bit(1'b0, 1'b0);
            rx_bit(1'b1, 1'b0);
            if (e == 254) check(err_ovf == 1'b0, "R12 no early overflow", err_ovf, 0);
        end
        check(err_ovf == 1'b1, "R12 overflow set", err_ovf, 1);
        do_load();
        check(err_hold == 0, "R12 wrapped count", err_hold, 0);
        check(bit_hold == 4096, "R10 long bit count", bit_hold, 4096);
        check(err_ovf == 1'b1, "R12 survives load", err_ovf, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check(err_ovf == 1'b0, "R12 cleared on read", err_ovf, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule